// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

A memory-mapped watchdog with two countdown stages in series. Once enabled, stage 1 counts down from its own preload value. When it expires it sets an interrupt-pending bit and can drive the interrupt output. In watchdog mode, stage 2 then loads from a second preload and counts down. When stage 2 expires the block raises a reset request and latches a timeout flag. That flag survives the bus reset, so software can learn after restart that the watchdog caused it. In plain timer mode, stage 1 restarts from its preload on every expiry and stage 2 is never used.

Both preloads and the reload register are protected. A key of 0x80 and then 0x86, written to byte 0 of the reload register, opens exactly one protected write. A sticky lock bit keeps software from turning the watchdog off. A prescaler makes the decrement tick at one of two rates.

The counting engine is a state machine with states OFF, STAGE1, STAGE2 and FIRED:
- OFF to STAGE1 when enabled, loading preload 1.
- STAGE1 to STAGE2 on a stage-1 expiry in watchdog mode, loading preload 2.
- STAGE1 to STAGE1 on an expiry in timer mode, reloading preload 1.
- STAGE2 to FIRED on a stage-2 expiry.
- STAGE1, STAGE2 or FIRED to STAGE1 on an accepted reload.
- Any state to OFF when the enable is cleared.

The key machine has states IDLE, ARMED and OPEN:
- IDLE to ARMED on key byte 0x80.
- ARMED to OPEN on 0x86.
- ARMED stays in ARMED on another 0x80.
- ARMED to IDLE on any other reload write.
- OPEN to IDLE on any protected write.

Top module: `dual_stage_wdt`

## Requirements
- R1: After the bus reset (`rst_ni` low), every register reads back zero and both outputs are low. The registers are: preload 1 at 0x00, preload 2 at 0x04, status at 0x08, reload at 0x0C, control at 0x10, config at 0x14 and count at 0x18.
- R2: A write to 0x00, 0x04 or 0x0C takes effect only after 0x80 and then 0x86 have been written to byte 0 of 0x0C. Exactly one such write is accepted per key; any other write to these registers is silently ignored.
- R3: While the key is incomplete, a reload-register write with a byte other than the expected next key byte returns the key machine to IDLE, so the full key must be written again.
- R4: With enable set (control bit 1), the first stage-1 expiry comes (P1+1) ticks after counting starts. It sets status bit 0. In watchdog mode (control bit 2 = 1), stage 2 then starts from preload 2.
- R5: Stage 2 expires (P2+1) ticks after it starts. It sets the timeout flag (reload register bit 9), and it drives `rst_req_o` high when config bit 5 is set.
- R6: In timer mode (control bit 2 = 0), stage 1 restarts from preload 1 on every expiry, and stage 2 and the reset request never occur.
- R7: An accepted write of 1 to reload register bit 8 restarts stage 1 from preload 1 with a fresh prescaler, and clears the pending interrupt and the reset request.
- R8: The timeout flag is unaffected by `rst_ni`. It is cleared by `por_ni` or by an accepted write of 1 to reload register bit 9.
- R9: Control bit 0 (lock), once set, stays set until a reset. While it is set, enable and mode cannot be cleared.
- R10: With config bit 2 = 0, one tick occurs every 2^SLOW_LOG2 clock cycles; with config bit 2 = 1, every 2^FAST_LOG2 clock cycles.
- R11: Config bits 1:0 set the interrupt kind:
  - 01: `irq_o` follows status bit 0 until a reload or disable.
  - 10: `irq_o` pulses for one cycle per stage-1 expiry.
  - 00 or 11: `irq_o` stays low.
- R12: Register 0x18 returns the live count in bits CNT_W-1:0 and, in bit CNT_W (bit 20 by default), a 1 while in stage 2 or after firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low bus reset |
| por_ni | input | 1 | Asynchronous active-low power-on reset for the timeout flag |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write enable |
| be_i | input | DATA_W/8 | Byte strobes |
| rdata_o | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Stage-1 interrupt |
| rst_req_o | output | 1 | System reset request |

## Verification
The bench builds the block with SLOW_LOG2 = 4 and FAST_LOG2 = 2, so a tick occurs every 16 or 4 cycles. Both expiries, repeated timer periods and the reload race then fit within a few hundred cycles each. CNT_W stays at 20, which keeps the count field and its stage bit at their real positions. Random preload values move each expiry edge, and the bench predicts that edge from the tick arithmetic.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} unlock_e;
    typedef enum logic [1:0] {CS_OFF, CS_STAGE1, CS_STAGE2, CS_FIRED} cstate_e;

    localparam logic [ADDR_W-1:0] OFS_PRE1   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE2   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    localparam logic [1:0] IRQ_LEVEL = 2'b01;
    localparam logic [1:0] IRQ_PULSE = 2'b10;
endpackage

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
    import wdt2_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       key_wr_i,
    input  logic       key_valid_i,
    input  logic [7:0] key_i,
    input  logic       prot_wr_i,
    output logic       open_o
);
    unlock_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UL_IDLE:
                if (key_wr_i && key_valid_i && key_i == KEY_FIRST) st_d = UL_ARMED;
            UL_ARMED:
                if (key_wr_i) begin
                    if (key_valid_i && key_i == KEY_SECOND)     st_d = UL_OPEN;
                    else if (key_valid_i && key_i == KEY_FIRST) st_d = UL_ARMED;
                    else                                        st_d = UL_IDLE;
                end
            UL_OPEN:
                if (prot_wr_i) st_d = UL_IDLE;
            default: st_d = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= UL_IDLE;
        else         st_q <= st_d;
    end

    always_comb open_o = (st_q == UL_OPEN);

    // R2
    unlock_single_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_o && prot_wr_i) |=> !open_o);
    // R2
    unlock_needs_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(open_o) |-> $past(key_wr_i && key_valid_i && key_i == KEY_SECOND));
    // R3
    unlock_bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!open_o && key_wr_i && !(key_valid_i && key_i == KEY_SECOND)) |=> !open_o);
endmodule

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    input  logic fast_i,
    output logic tick_o
);
    logic [SLOW_LOG2-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                pre_q <= '0;
        else if (!run_i || clear_i) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
    end

    always_comb tick_o = run_i && (fast_i ? (&pre_q[FAST_LOG2-1:0]) : (&pre_q));

    // R10
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter
    import wdt2_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             wd_mode_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] pre1_i,
    input  logic [CNT_W-1:0] pre2_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             in_stage2_o,
    output logic             fired_o,
    output logic             running_o,
    output logic             s1_exp_o,
    output logic             s2_exp_o
);
    cstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_zero;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        s1_exp_o = 1'b0;
        s2_exp_o = 1'b0;
        at_zero  = (cnt_q == '0);
        if (!en_i) begin
            st_d = CS_OFF;
        end else begin
            unique case (st_q)
                CS_OFF: begin
                    st_d  = CS_STAGE1;
                    cnt_d = pre1_i;
                end
                CS_STAGE1:
                    if (reload_i) cnt_d = pre1_i;
                    else if (tick_i) begin
                        if (at_zero) begin
                            s1_exp_o = 1'b1;
                            if (wd_mode_i) begin
                                st_d  = CS_STAGE2;
                                cnt_d = pre2_i;
                            end else begin
                                cnt_d = pre1_i;
                            end
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                CS_STAGE2:
                    if (reload_i) begin
                        st_d  = CS_STAGE1;
                        cnt_d = pre1_i;
                    end else if (tick_i) begin
                        if (at_zero) begin
                            s2_exp_o = 1'b1;
                            st_d     = CS_FIRED;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                CS_FIRED:
                    if (reload_i) begin
                        st_d  = CS_STAGE1;
                        cnt_d = pre1_i;
                    end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= CS_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        cnt_o       = cnt_q;
        in_stage2_o = (st_q == CS_STAGE2) || (st_q == CS_FIRED);
        fired_o     = (st_q == CS_FIRED);
        running_o   = (st_q == CS_STAGE1) || (st_q == CS_STAGE2);
    end

    // R4
    stage2_after_stage1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q == CS_STAGE2) |-> $past(s1_exp_o));
    // R5
    fire_after_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s2_exp_o |=> (fired_o || !en_i));
    // R6
    timer_mode_no_stage2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == CS_STAGE1 && !wd_mode_i) |=> (st_q != CS_STAGE2));
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
    import wdt2_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int DATA_W    = 32,
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  por_ni,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  we_i,
    input  logic [DATA_W/8-1:0]   be_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  irq_o,
    output logic                  rst_req_o
);
    localparam int NBE     = DATA_W / 8;
    localparam int BE_USED = (CNT_W + 7) / 8;

    logic [CNT_W-1:0] pre1_q, pre2_q, wmask, cnt;
    logic lock_q, en_q, mode_q, rst_en_q, fast_q;
    logic [1:0] irqk_q;
    logic irq_pend_q, pulse_q, tout_q;
    logic hit_pre1, hit_pre2, hit_reload, hit_ctrl, hit_cfg;
    logic prot_wr, key_open, accept, reload_req, clr_flag;
    logic tick, running, stage2, fired, s1_exp, s2_exp;
    logic unused_bits;

    assign unused_bits = ^{wdata_i[DATA_W-1:CNT_W], be_i[NBE-1:BE_USED]};

    always_comb begin
        hit_pre1   = (addr_i == OFS_PRE1);
        hit_pre2   = (addr_i == OFS_PRE2);
        hit_reload = (addr_i == OFS_RELOAD);
        hit_ctrl   = (addr_i == OFS_CTRL);
        hit_cfg    = (addr_i == OFS_CFG);
        prot_wr    = we_i && (hit_pre1 || hit_pre2 || hit_reload);
        accept     = prot_wr && key_open;
        reload_req = accept && hit_reload && be_i[1] && wdata_i[8];
        clr_flag   = accept && hit_reload && be_i[1] && wdata_i[9];
        for (int i = 0; i < CNT_W; i++) wmask[i] = be_i[i/8];
    end

    wdt2_unlock i_unlock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .key_wr_i   (we_i && hit_reload),
        .key_valid_i(be_i[0]),
        .key_i      (wdata_i[7:0]),
        .prot_wr_i  (prot_wr),
        .open_o     (key_open)
    );

    wdt2_prescaler #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) i_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (running),
        .clear_i(reload_req),
        .fast_i (fast_q),
        .tick_o (tick)
    );

    wdt2_counter #(.CNT_W(CNT_W)) i_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_q),
        .wd_mode_i  (mode_q),
        .tick_i     (tick),
        .reload_i   (reload_req),
        .pre1_i     (pre1_q),
        .pre2_i     (pre2_q),
        .cnt_o      (cnt),
        .in_stage2_o(stage2),
        .fired_o    (fired),
        .running_o  (running),
        .s1_exp_o   (s1_exp),
        .s2_exp_o   (s2_exp)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre1_q <= '0;  pre2_q <= '0;
            lock_q <= 1'b0; en_q <= 1'b0; mode_q <= 1'b0;
            rst_en_q <= 1'b0; fast_q <= 1'b0; irqk_q <= 2'b00;
            irq_pend_q <= 1'b0; pulse_q <= 1'b0;
        end else begin
            if (accept && hit_pre1) pre1_q <= (pre1_q & ~wmask) | (wdata_i[CNT_W-1:0] & wmask);
            if (accept && hit_pre2) pre2_q <= (pre2_q & ~wmask) | (wdata_i[CNT_W-1:0] & wmask);
            if (we_i && hit_ctrl && be_i[0]) begin
                lock_q <= lock_q | wdata_i[0];
                en_q   <= lock_q ? (en_q | wdata_i[1]) : wdata_i[1];
                mode_q <= lock_q ? (mode_q | wdata_i[2]) : wdata_i[2];
            end
            if (we_i && hit_cfg && be_i[0]) begin
                rst_en_q <= wdata_i[5];
                fast_q   <= wdata_i[2];
                irqk_q   <= wdata_i[1:0];
            end
            if (!en_q || reload_req) irq_pend_q <= 1'b0;
            else if (s1_exp)         irq_pend_q <= 1'b1;
            pulse_q <= s1_exp && (irqk_q == IRQ_PULSE);
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni)       tout_q <= 1'b0;
        else if (s2_exp)   tout_q <= 1'b1;
        else if (clr_flag) tout_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_PRE1:   rdata_o[CNT_W-1:0] = pre1_q;
            OFS_PRE2:   rdata_o[CNT_W-1:0] = pre2_q;
            OFS_STAT:   rdata_o[0] = irq_pend_q;
            OFS_RELOAD: rdata_o[9] = tout_q;
            OFS_CTRL:   rdata_o[2:0] = {mode_q, en_q, lock_q};
            OFS_CFG:    rdata_o[5:0] = {rst_en_q, 2'b00, fast_q, irqk_q};
            OFS_COUNT:  rdata_o[CNT_W:0] = {stage2, cnt};
            default:    rdata_o = '0;
        endcase
        irq_o     = ((irqk_q == IRQ_LEVEL) && irq_pend_q) || pulse_q;
        rst_req_o = fired && rst_en_q;
    end

    // R9
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> lock_q);
    // R9
    locked_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_q && en_q) |=> en_q);
    // R5
    flag_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
        s2_exp |=> tout_q);
    // R5
    reset_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
        rst_req_o |-> tout_q);
    // R7
    reload_quiets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_req |=> (!irq_o && !rst_req_o));
endmodule

// File: tb/test_dual_stage_wdt.sv
`timescale 1ns/1ps
module test_dual_stage_wdt;
    localparam int SL = 4;
    localparam int FL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;

    int cyc = 0, n_chk = 0, n_bad = 0, last_wr = 0, hi_cnt = 0;
    logic [31:0] v;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (irq) hi_cnt <= hi_cnt + 1;

    dual_stage_wdt #(.CNT_W(20), .DATA_W(32), .SLOW_LOG2(SL), .FAST_LOG2(FL)) i_dual_stage_wdt (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .addr_i(addr), .wdata_i(wdata),
        .we_i(we), .be_i(be), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req));

    function automatic int exp_span(input int p, input int lg);
        return (p + 1) << lg;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk); addr = a; wdata = d; be = b; we = 1'b1;
        @(negedge clk); we = 1'b0; last_wr = cyc;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic unlock();
        wr(5'h0C, 32'h80, 4'b0001);
        wr(5'h0C, 32'h86, 4'b0001);
    endtask

    task automatic pwr(input logic [4:0] a, input logic [31:0] d);
        unlock(); wr(a, d, 4'b1111);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e, t1, t2, p1, p2, r;
        v = $urandom(32'd1977);
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(5'(a * 4), v); check("R1 reg", v, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 0); check("R1 rst_req", {31'b0, rst_req}, 0);

        // R2 protection and single use
        wr(5'h00, 32'd9, 4'b1111); rd(5'h00, v); check("R2 no key", v, 0);
        pwr(5'h00, 32'd9); rd(5'h00, v); check("R2 keyed", v, 9);
        wr(5'h00, 32'd3, 4'b1111); rd(5'h00, v); check("R2 one write", v, 9);

        // R3 broken key sequence
        wr(5'h0C, 32'h80, 4'b0001); wr(5'h0C, 32'h55, 4'b0001); wr(5'h0C, 32'h86, 4'b0001);
        wr(5'h04, 32'd7, 4'b1111); rd(5'h04, v); check("R3 bad key", v, 0);
        pwr(5'h04, 32'd7); rd(5'h04, v); check("R3 rekey", v, 7);

        // R4 R5 R11 R12 random preloads, watchdog mode, level irq
        for (int it = 0; it < 3; it++) begin
            p1 = $urandom_range(12, 1); p2 = $urandom_range(8, 0);
            pwr(5'h00, p1); pwr(5'h04, p2);
            wr(5'h14, 32'h21, 4'b0001);
            wr(5'h10, 32'h06, 4'b0001); e = last_wr;
            t1 = e + 1 + exp_span(p1, SL);
            t2 = t1 + exp_span(p2, SL);
            wait_until(e + 20); rd(5'h18, v); check("R12 count", v, 32'(p1 - 1));
            wait_until(t1 - 2); check("R4 early", {31'b0, irq}, 0);
            wait_until(t1 + 1); check("R11 level", {31'b0, irq}, 1);
            rd(5'h08, v); check("R4 status", v, 1);
            rd(5'h18, v); check("R12 stage2", v, (32'd1 << 20) | 32'(p2));
            wait_until(t2 - 2); check("R5 early", {31'b0, rst_req}, 0);
            wait_until(t2 + 1); check("R5 rst_req", {31'b0, rst_req}, 1);
            rd(5'h0C, v); check("R5 flag", v, 32'h200);
            wr(5'h10, 32'h0, 4'b0001);
            unlock(); wr(5'h0C, 32'h200, 4'b0010);
            rd(5'h0C, v); check("R8 clear", v, 0);
        end

        // R7 reloads prevent expiry and restart stage 1
        pwr(5'h00, 3); wr(5'h14, 32'h21, 4'b0001);
        wr(5'h10, 32'h06, 4'b0001);
        r = 0;
        for (int k = 0; k < 4; k++) begin
            wait_until(cyc + 30); unlock(); wr(5'h0C, 32'h100, 4'b0010); r = last_wr;
            check("R7 no irq", {31'b0, irq}, 0);
        end
        rd(5'h08, v); check("R7 status", v, 0);
        wait_until(r + exp_span(3, SL) - 2); check("R7 restart early", {31'b0, irq}, 0);
        wait_until(r + exp_span(3, SL) + 1); check("R7 restart", {31'b0, irq}, 1);
        unlock(); wr(5'h0C, 32'h100, 4'b0010); check("R7 clears irq", {31'b0, irq}, 0);
        wr(5'h10, 32'h0, 4'b0001);

        // R10 fast rate
        pwr(5'h00, 5); wr(5'h14, 32'h25, 4'b0001);
        wr(5'h10, 32'h06, 4'b0001); e = last_wr; t1 = e + 1 + exp_span(5, FL);
        wait_until(t1 - 2); check("R10 early", {31'b0, irq}, 0);
        wait_until(t1 + 1); check("R10 fast", {31'b0, irq}, 1);
        wr(5'h10, 32'h0, 4'b0001);

        // R11 none kind
        pwr(5'h00, 1); wr(5'h14, 32'h20, 4'b0001);
        wr(5'h10, 32'h06, 4'b0001); e = last_wr;
        wait_until(e + 1 + exp_span(1, SL) + 4);
        check("R11 none", {31'b0, irq}, 0);
        rd(5'h08, v); check("R11 none status", v, 1);
        wr(5'h10, 32'h0, 4'b0001);

        // R6 timer mode with pulse kind
        pwr(5'h00, 2); pwr(5'h04, 0); wr(5'h14, 32'h22, 4'b0001);
        wr(5'h10, 32'h02, 4'b0001); e = last_wr; hi_cnt = 0;
        wait_until(e + 1 + 3 * exp_span(2, SL) + 5);
        check("R11 pulses", hi_cnt, 3);
        check("R6 no reset", {31'b0, rst_req}, 0);
        rd(5'h18, v); check("R6 stage1", {31'b0, v[20]}, 0);
        rd(5'h0C, v); check("R6 no flag", v, 0);
        wr(5'h10, 32'h0, 4'b0001);

        // R9 lock, then R8 flag across bus reset
        pwr(5'h00, 8); pwr(5'h04, 1); wr(5'h14, 32'h21, 4'b0001);
        wr(5'h10, 32'h07, 4'b0001); e = last_wr;
        wr(5'h10, 32'h0, 4'b0001); rd(5'h10, v); check("R9 locked", v, 7);
        wait_until(e + 52); rd(5'h18, v); check("R9 still counting", v, 5);
        wait_until(e + 1 + exp_span(8, SL) + exp_span(1, SL) + 2);
        check("R9 fired", {31'b0, rst_req}, 1);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(5'h10, v); check("R9 reset clears lock", v, 0);
        rd(5'h0C, v); check("R8 survives", v, 32'h200);
        check("R8 rst_req low", {31'b0, rst_req}, 0);
        @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        rd(5'h0C, v); check("R8 por", v, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule